// File: doc/BRIEF.md
# Sync Header Payload DMA Packer

This block sits between a receive-side 64b/66b block stream and a host DMA engine with a 128-bit write path. Each incoming 66-bit block is split in two: its 2-bit sync header and its 64-bit payload. Payloads are paired, so every 128-bit write beat carries two of them. Headers are gathered sixteen to a 32-bit word and held on chip until the page is complete. Storing one 66-bit block per bus word would leave about half of each beat empty; this layout avoids that.

A page holds `BLOCKS_PER_PAGE` blocks, a multiple of 32. The payload region starts at byte offset 0, with slot i at offset 8*i. The header region starts right after it, at offset 8*`BLOCKS_PER_PAGE`. Header word w sits at offset 8*`BLOCKS_PER_PAGE` + 4*w. The default of 480 blocks fills 3840 bytes of payload plus 128 bytes of headers, which fits a 4 KB page.

After the header beats of a page have gone out, the block raises a one-cycle page-complete pulse. It then moves to the next page index, which wraps at the ring size.

Both stream edges use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. Once the output has raised `beat_valid`, it holds the beat unchanged until `beat_ready` takes it. The input drops `blk_ready` whenever the block just offered would complete a payload pair while the output register is still occupied and not draining. It also holds `blk_ready` low for the whole header phase. No accepted block is ever dropped.

Top module: `shp_packer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `beat_valid` and `page_done` are 0, `page_idx` is 0 and `blk_ready` is 1. A reset in the middle of a page discards the partial page, and the next accepted block becomes block 0 of page 0.
- R2: Blocks 2k and 2k+1 of a page form payload beat k. The payload of block 2k is in `beat_data[63:0]`, the payload of block 2k+1 is in `beat_data[127:64]`, and `beat_addr` is 16*k.
- R3: The header of block i occupies bits [2*(i mod 16)+1 : 2*(i mod 16)] of header word i/16. Header word w occupies bits [32*(w mod 4)+31 : 32*(w mod 4)] of header beat w/4. Lanes past the last header word of the page are zero.
- R4: Header beats follow the last payload beat of the page, in increasing order. Header beat b has `beat_addr` 8*`BLOCKS_PER_PAGE` + 16*b.
- R5: A page produces exactly `BLOCKS_PER_PAGE`/2 + ceil(`BLOCKS_PER_PAGE`/64) beats. `page_done` is high for exactly one cycle: the cycle after the last header beat is transferred.
- R6: `page_idx` increases by one, modulo `RING_PAGES`, in the same cycle that `page_done` is high. At all other times it holds its value.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, `beat_valid`, `beat_data` and `beat_addr` hold their values into the next cycle.
- R8: `blk_ready` is 0 when the offered block would complete a pair and the output beat is held. It is also 0 throughout the header phase. Every accepted block appears exactly once in the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Input block valid |
| blk_ready | output | 1 | Input block accepted when high together with valid |
| blk_hdr | input | 2 | Sync header of the offered block |
| blk_payload | input | 64 | Payload of the offered block |
| beat_valid | output | 1 | Write beat valid |
| beat_ready | input | 1 | Host side accepts the beat |
| beat_data | output | 128 | Write beat data |
| beat_addr | output | 12 | Byte offset of the beat inside the page |
| page_idx | output | $clog2(RING_PAGES) | Ring page the beats belong to |
| page_done | output | 1 | One-cycle pulse after the last beat of a page |

## Verification
The properties assume that the input side follows the usual handshake: an offered block is only counted when `blk_valid` and `blk_ready` are both high at an edge. They put no constraint on how `beat_ready` behaves.

The bench holds each block's header and payload steady until it is accepted. It drives `beat_ready` in several patterns: always high, alternating, pseudo-random, one-in-four, and held low for a long stretch. This way both the pair stall and the header-phase stall occur while input gaps are also present. The page index is exercised across several wraps of a small ring, and a reset is applied in the middle of a page.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int BEAT_W = 128;
  localparam int PAY_W  = 64;
  localparam int HDR_W  = 2;
  localparam int WORD_W = 32;
  localparam int HDRS_PER_WORD  = WORD_W / HDR_W;
  localparam int WORDS_PER_BEAT = BEAT_W / WORD_W;
  localparam int BEAT_BYTES     = BEAT_W / 8;
  localparam int PAY_BYTES      = PAY_W / 8;

  typedef enum logic [1:0] {
    ST_PAY   = 2'd0,
    ST_HDR   = 2'd1,
    ST_DRAIN = 2'd2
  } shp_state_e;

  function automatic int hdr_beats(input int blocks);
    return (blocks / HDRS_PER_WORD + WORDS_PER_BEAT - 1) / WORDS_PER_BEAT;
  endfunction

endpackage

// File: rtl/shp_hdr_buf.sv
module shp_hdr_buf
  import shp_pkg::*;
#(
  parameter int BLOCKS = 480
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(BLOCKS)-1:0]     wr_idx,
  input  logic [HDR_W-1:0]              wr_hdr,
  input  logic [((hdr_beats(BLOCKS) > 1) ? $clog2(hdr_beats(BLOCKS)) : 1)-1:0] rd_beat,
  output logic [BEAT_W-1:0]             rd_data
);

  localparam int IW    = $clog2(BLOCKS);
  localparam int WORDS = BLOCKS / HDRS_PER_WORD;
  localparam int BEATS = hdr_beats(BLOCKS);
  localparam int SELW  = IW - 4;

  logic [WORD_W-1:0] word_q [WORDS];
  logic [BEAT_W-1:0] beat_vec [BEATS];

  // one storage word per group of sixteen headers
  for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[gw] <= '0;
      end else if (wr_en && (wr_idx[IW-1:4] == SELW'(gw))) begin
        word_q[gw][{wr_idx[3:0], 1'b0} +: HDR_W] <= wr_hdr;
      end
    end
  end

  // beat lanes: four words each, zero past the last word
  for (genvar gb = 0; gb < BEATS; gb++) begin : g_beat
    for (genvar gl = 0; gl < WORDS_PER_BEAT; gl++) begin : g_lane
      if (gb * WORDS_PER_BEAT + gl < WORDS) begin : g_used
        assign beat_vec[gb][gl*WORD_W +: WORD_W] = word_q[gb*WORDS_PER_BEAT + gl];
      end else begin : g_pad
        assign beat_vec[gb][gl*WORD_W +: WORD_W] = '0;
      end
    end
  end

  assign rd_data = beat_vec[rd_beat];

endmodule

// File: rtl/shp_page_ctr.sv
module shp_page_ctr #(
  parameter int RING_PAGES = 64,
  localparam int PW = (RING_PAGES > 1) ? $clog2(RING_PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] idx
);

  logic [PW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= (idx_q == PW'(RING_PAGES - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/shp_packer.sv
module shp_packer
  import shp_pkg::*;
#(
  parameter int BLOCKS_PER_PAGE = 480,
  parameter int RING_PAGES      = 64,
  parameter int PAGE_BYTES      = 4096,
  localparam int ADDR_W = $clog2(PAGE_BYTES),
  localparam int PAGE_W = (RING_PAGES > 1) ? $clog2(RING_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [1:0]        blk_hdr,
  input  logic [63:0]       blk_payload,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [127:0]      beat_data,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [PAGE_W-1:0] page_idx,
  output logic              page_done
);

  localparam int IW       = $clog2(BLOCKS_PER_PAGE);
  localparam int HBEATS   = hdr_beats(BLOCKS_PER_PAGE);
  localparam int HBW      = (HBEATS > 1) ? $clog2(HBEATS) : 1;
  localparam int HDR_BASE = BLOCKS_PER_PAGE * PAY_BYTES;

  shp_state_e        state_q;
  logic [IW-1:0]     blk_q;
  logic              have_lo_q;
  logic [PAY_W-1:0]  lo_q;
  logic [HBW-1:0]    hb_q;
  logic              ov_q;
  logic [BEAT_W-1:0] od_q;
  logic [ADDR_W-1:0] oa_q;
  logic              done_q;
  logic [BEAT_W-1:0] hdr_beat;

  logic out_free, accept, last_blk, last_hb, page_adv;

  assign out_free  = !ov_q || beat_ready;
  assign blk_ready = (state_q == ST_PAY) && (!have_lo_q || out_free);
  assign accept    = blk_valid && blk_ready;
  assign last_blk  = (blk_q == IW'(BLOCKS_PER_PAGE - 1));
  assign last_hb   = (hb_q == HBW'(HBEATS - 1));
  assign page_adv  = (state_q == ST_DRAIN) && ov_q && beat_ready;

  shp_hdr_buf #(
    .BLOCKS (BLOCKS_PER_PAGE)
  ) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_idx  (blk_q),
    .wr_hdr  (blk_hdr),
    .rd_beat (hb_q),
    .rd_data (hdr_beat)
  );

  shp_page_ctr #(
    .RING_PAGES (RING_PAGES)
  ) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (page_adv),
    .idx   (page_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_PAY;
      blk_q     <= '0;
      have_lo_q <= 1'b0;
      lo_q      <= '0;
      hb_q      <= '0;
      ov_q      <= 1'b0;
      od_q      <= '0;
      oa_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ov_q && beat_ready) ov_q <= 1'b0;
      unique case (state_q)
        ST_PAY: begin
          if (accept) begin
            blk_q <= last_blk ? '0 : blk_q + 1'b1;
            if (!have_lo_q) begin
              lo_q      <= blk_payload;
              have_lo_q <= 1'b1;
            end else begin
              have_lo_q <= 1'b0;
              ov_q      <= 1'b1;
              od_q      <= {blk_payload, lo_q};
              oa_q      <= ADDR_W'((32'(blk_q) >> 1) * BEAT_BYTES);
            end
            if (last_blk) begin
              state_q <= ST_HDR;
              hb_q    <= '0;
            end
          end
        end
        ST_HDR: begin
          if (out_free) begin
            ov_q <= 1'b1;
            od_q <= hdr_beat;
            oa_q <= ADDR_W'(HDR_BASE + 32'(hb_q) * BEAT_BYTES);
            if (last_hb) state_q <= ST_DRAIN;
            else         hb_q    <= hb_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (page_adv) begin
            done_q  <= 1'b1;
            state_q <= ST_PAY;
          end
        end
        default: state_q <= ST_PAY;
      endcase
    end
  end

  assign beat_valid = ov_q;
  assign beat_data  = od_q;
  assign beat_addr  = oa_q;
  assign page_done  = done_q;

endmodule

// File: rtl/shp_packer_chk.sv
module shp_packer_chk #(
  parameter int N    = 480,
  parameter int RING = 64,
  parameter int AW   = 12,
  parameter int PW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_ready,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [127:0]  beat_data,
  input logic [AW-1:0] beat_addr,
  input logic [PW-1:0] page_idx,
  input logic          page_done
);

  localparam int HBEATS = (N / 16 + 3) / 4;
  localparam logic [AW-1:0] HDR_BASE  = AW'(N * 8);
  localparam logic [AW-1:0] LAST_ADDR = AW'(N * 8 + 16 * (HBEATS - 1));

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_data) && $stable(beat_addr)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> $past(beat_valid && beat_ready && beat_addr == LAST_ADDR)); // R5

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> page_idx == (($past(page_idx) == PW'(RING - 1)) ? '0 : $past(page_idx) + 1'b1)); // R6

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !page_done |-> $stable(page_idx)); // R6

  AST_NO_INPUT_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_addr >= HDR_BASE |-> !blk_ready); // R8

  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_addr[3:0] == 4'd0); // R2

endmodule

bind shp_packer shp_packer_chk #(
  .N    (BLOCKS_PER_PAGE),
  .RING (RING_PAGES),
  .AW   (ADDR_W),
  .PW   (PAGE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_ready  (blk_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_data  (beat_data),
  .beat_addr  (beat_addr),
  .page_idx   (page_idx),
  .page_done  (page_done)
);

// File: tb/shp_packer_tb.sv
module shp_packer_tb;

  localparam int CLK_NS = 10;
  localparam int N      = 32;
  localparam int RING   = 4;
  localparam int AW     = 12;
  localparam int PW     = 2;
  localparam int PBEATS = N / 2;
  localparam int NBEATS = PBEATS + (N / 16 + 3) / 4;

  typedef struct packed {
    logic [63:0] seed;
    logic [1:0]  rmode;
    logic        gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'h0123_4567_89AB_CDEF, 2'd0, 1'b0},
    '{64'hFFFF_0000_FFFF_0000, 2'd1, 1'b0},
    '{64'h5A5A_A5A5_3C3C_C3C3, 2'd2, 1'b1},
    '{64'h0000_0000_0000_0001, 2'd3, 1'b0},
    '{64'hDEAD_BEEF_CAFE_F00D, 2'd2, 1'b0},
    '{64'h8000_0000_0000_0002, 2'd0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          blk_valid;
  logic          blk_ready;
  logic [1:0]    blk_hdr;
  logic [63:0]   blk_payload;
  logic          beat_valid;
  logic          beat_ready;
  logic [127:0]  beat_data;
  logic [AW-1:0] beat_addr;
  logic [PW-1:0] page_idx;
  logic          page_done;

  int n_tests = 0;
  int n_fail  = 0;
  int page_exp = 0;
  logic finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  shp_packer #(
    .BLOCKS_PER_PAGE (N),
    .RING_PAGES      (RING)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_valid   (blk_valid),
    .blk_ready   (blk_ready),
    .blk_hdr     (blk_hdr),
    .blk_payload (blk_payload),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_data   (beat_data),
    .beat_addr   (beat_addr),
    .page_idx    (page_idx),
    .page_done   (page_done)
  );

  function automatic logic [63:0] pay_of(input logic [63:0] seed, input int i);
    return seed ^ (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  function automatic logic [1:0] hdr_of(input logic [63:0] seed, input int i);
    return 2'(seed[1:0] + 2'(i) + 2'(i >> 3) + 2'(i >> 5));
  endfunction

  function automatic logic [127:0] exp_beat(input logic [63:0] seed, input int b);
    logic [127:0] r;
    r = '0;
    if (b < PBEATS) begin
      r = {pay_of(seed, 2*b + 1), pay_of(seed, 2*b)};
    end else begin
      for (int w = 0; w < 4; w++) begin
        int word;
        word = 4 * (b - PBEATS) + w;
        if (word < N / 16)
          for (int k = 0; k < 16; k++)
            r[32*w + 2*k +: 2] = hdr_of(seed, 16*word + k);
      end
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int b);
    return (b < PBEATS) ? AW'(16 * b) : AW'(N * 8 + 16 * (b - PBEATS));
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_page(input logic [63:0] seed, input logic [1:0] rmode, input logic gap, input int hold);
    if (hold > 0) beat_ready = 1'b0;
    fork
      begin : drv
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
          if (gap && (i % 3 == 1)) begin
            blk_valid = 1'b0;
            @(negedge clk);
          end
          blk_valid   = 1'b1;
          blk_hdr     = hdr_of(seed, i);
          blk_payload = pay_of(seed, i);
          while (!blk_ready) @(negedge clk);
          @(negedge clk);
        end
        blk_valid = 1'b0;
      end
      begin : col
        int nb, ci;
        logic seen, prev_stall;
        logic [127:0] prev_d;
        logic [AW-1:0] prev_a;
        logic [15:0] lf;
        nb = 0; ci = 0; seen = 1'b0; prev_stall = 1'b0; lf = 16'hACE1 ^ seed[15:0];
        prev_d = '0; prev_a = '0;
        while (!seen) begin
          @(posedge clk);
          #1;
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (ci < hold) beat_ready = 1'b0;
          else case (rmode)
            2'd0: beat_ready = 1'b1;
            2'd1: beat_ready = ci[0];
            2'd2: beat_ready = lf[0];
            default: beat_ready = (ci % 4 == 0);
          endcase
          ci++;
          @(negedge clk);
          if (prev_stall) begin
            // R7: held beat must not change
            check(beat_valid && beat_data == prev_d && beat_addr == prev_a, "R7 held beat",
                  {beat_addr, beat_data[115:0]}, {prev_a, prev_d[115:0]});
          end
          prev_stall = beat_valid && !beat_ready;
          prev_d = beat_data;
          prev_a = beat_addr;
          if (beat_valid && beat_ready) begin
            if (nb < NBEATS) begin
              check(beat_data == exp_beat(seed, nb), (nb < PBEATS) ? "R2 payload data" : "R3 header data",
                    beat_data, exp_beat(seed, nb));
              check(beat_addr == exp_addr(nb), (nb < PBEATS) ? "R2 payload addr" : "R4 header addr",
                    128'(beat_addr), 128'(exp_addr(nb)));
            end
            nb++;
          end
          if (page_done) begin
            seen = 1'b1;
            check(nb == NBEATS, "R5 beats per page and R8 no block lost", 128'(nb), 128'(NBEATS));
            page_exp = (page_exp + 1) % RING;
            check(page_idx == PW'(page_exp), "R6 page index step", 128'(page_idx), 128'(page_exp));
          end
        end
      end
      begin : stall_probe
        if (hold > 0) begin
          repeat (12) @(negedge clk);
          // R8: pair complete, output held, input must stall
          check(!blk_ready, "R8 stall on held beat", 128'(blk_ready), 128'(0));
          check(beat_valid && beat_addr == '0, "R8 held first beat", 128'(beat_addr), 128'(0));
        end
      end
    join
    @(negedge clk);
    check(!page_done, "R5 done is one cycle", 128'(page_done), 128'(0));
    check(page_idx == PW'(page_exp), "R6 page index held", 128'(page_idx), 128'(page_exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1..R8 run hung actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; blk_valid = 1'b0; blk_hdr = '0; blk_payload = '0; beat_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!beat_valid && !page_done, "R1 reset outputs quiet", {beat_valid, page_done}, 0);
    check(page_idx == '0 && blk_ready, "R1 reset index and ready", {page_idx, blk_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid && page_idx == '0 && blk_ready, "R1 after release",
          {beat_valid, page_idx, blk_ready}, 1);

    for (int v = 0; v < 6; v++)
      run_page(VECS[v].seed, VECS[v].rmode, VECS[v].gap, 0);

    // directed: long output stall at the start of a page
    run_page(64'h1357_9BDF_2468_ACE0, 2'd0, 1'b0, 20);

    // directed: reset in the middle of a page discards it
    beat_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      blk_valid = 1'b1; blk_hdr = 2'd3; blk_payload = 64'hFFFF_FFFF_FFFF_FFFF;
      @(negedge clk);
    end
    blk_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid && page_idx == '0 && blk_ready, "R1 mid-page reset",
          {beat_valid, page_idx, blk_ready}, 1);
    page_exp = 0;
    run_page(64'h2222_4444_6666_8888, 2'd1, 1'b1, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule